// File: doc/BRIEF.md
# Three-Phase Hall Commutation Controller

This block turns three Hall sensor levels into six gate enables for a three-phase half-bridge, using plain 120-degree conduction. For every valid rotor position one phase has its high-side switch held on and another phase has its low-side switch chopped by a PWM. While that low-side switch is in its off-time, the high-side switch of the same phase is turned on to carry the freewheel current (synchronous rectification). A dead interval separates the two switches of a phase in both directions of every handover.

Level inputs select the mode:
- **Run:** when low, the bridge stops.
- **Brake:** shorts the motor through all three low sides.
- **Direction:** reverses rotation by complementing the Hall code before the table lookup.

A 10-bit duty value is compared against a free-running counter to set the on-time. A current-limit comparator ends the on-time early for the rest of the current PWM period.

Fault inputs act in two classes:
- **Stall, clock loss and over-temperature:** remove only the low sides while driving.
- **Undervoltage and the initial-reset hold:** remove every output.

Top module: `bldc_commutator`

## Requirements
- R1: Phases are indexed U=0, V=1, W=2 and the Hall code is {hall[2],hall[1],hall[0]}. With dir_rev=0 the code selects (high-side phase, PWM low-side phase) as follows: 101→(V,U), 100→(W,U), 110→(W,V), 010→(U,V), 011→(U,W), 001→(V,W). The high-side phase is on for the whole PWM period, and the third phase is fully off.
- R2: With dir_rev=1 the bitwise complement of the Hall code is looked up in the R1 table.
- R3: Hall codes 000 and 111 turn all six enables off.
- R4: With run=0 all six enables are off, regardless of brake, Hall code and duty.
- R5: With run=1 and brake=1, all three low sides are on continuously and all high sides are off. This holds independently of duty, ilim_trip and the stall, clock-loss and over-temperature flags.
- R6: Only the low side is modulated. The PWM period is 2^CNT_W clocks. In each period the low side of the PWM phase is on for duty-DEAD_CYC-1 clocks, for DEAD_CYC+2 ≤ duty ≤ 2^CNT_W-3-DEAD_CYC.
- R7: In the off-time, the high side of the PWM phase is on for 2^CNT_W-1-duty-DEAD_CYC clocks per period, within the same duty range as R6. With duty=0 it is on continuously and the low side never turns on.
- R8: After either switch of a phase turns off, the other switch of that phase stays off for at least DEAD_CYC clocks.
- R9: A one-clock ilim_trip pulse turns the PWM low side off within two clocks, and it stays off for the rest of that PWM period. The next period runs at full on-time. With ilim_trip held high the low side never turns on.
- R10: While driving, any of flt_stall, flt_clkloss or flt_therm forces all low sides off and suppresses synchronous rectification. The selected high side stays on.
- R11: The following force all six enables off, even with brake=1:
  - flt_uvlo=1;
  - init_hold=1;
  - rst_n low.
- R12: The high-side and low-side enables of one phase are never on in the same clock, including across changes of direction and Hall code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall | input | 3 | Hall sensor levels, bit 2 = sensor 1 |
| dir_rev | input | 1 | 1 = reverse rotation |
| run | input | 1 | 1 = drive enabled, 0 = stop |
| brake | input | 1 | 1 = short brake |
| duty | input | CNT_W | PWM on-time compare value |
| ilim_trip | input | 1 | Current-limit comparator output |
| flt_stall | input | 1 | Stall fault, removes low sides |
| flt_clkloss | input | 1 | Speed-reference loss fault, removes low sides |
| flt_therm | input | 1 | Over-temperature fault, removes low sides |
| flt_uvlo | input | 1 | Undervoltage, removes all outputs |
| init_hold | input | 1 | Initial-reset hold, removes all outputs |
| hs_en | output | 3 | High-side gate enables, index U,V,W |
| ls_en | output | 3 | Low-side gate enables, index U,V,W |

## Verification
The commutation table is driven with all six valid codes in both directions, with both invalid codes, and with random code, direction and duty triples. Per-period on-counts of every enable separate the three roles of a phase: held high, chopped low with rectifying high, and idle. They also expose an off-by-one in the dead interval or in the duty compare. Mode patterns include:
- stop;
- brake with the current limit and a low-side fault active;
- undervoltage over brake;
- low-side faults while driving.

These show which input wins. A single trip pulse placed inside an on-time, and a trip held high, tell a per-period latch apart from one that leaks into the next period or ignores the comparator. Continuous monitoring across random direction flips checks overlap and the dead interval at every handover.

// File: rtl/bldc_pkg.sv
package bldc_pkg;

    localparam int PH = 3;  // U=0, V=1, W=2

    typedef struct packed {
        logic          valid;
        logic [PH-1:0] hi;   // one-hot high-side phase
        logic [PH-1:0] lo;   // one-hot PWM low-side phase
    } step_t;

    // Forward six-step table; index order of phases is U,V,W.
    function automatic step_t step_lookup(input logic [2:0] code);
        step_t s;
        s = '0;
        s.valid = 1'b1;
        unique case (code)
            3'b101:  begin s.hi = 3'b010; s.lo = 3'b001; end
            3'b100:  begin s.hi = 3'b100; s.lo = 3'b001; end
            3'b110:  begin s.hi = 3'b100; s.lo = 3'b010; end
            3'b010:  begin s.hi = 3'b001; s.lo = 3'b010; end
            3'b011:  begin s.hi = 3'b001; s.lo = 3'b100; end
            3'b001:  begin s.hi = 3'b010; s.lo = 3'b100; end
            default: s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/hall_decoder.sv
module hall_decoder
    import bldc_pkg::*;
(
    input  logic [2:0] hall,
    input  logic       dir_rev,
    output step_t      step
);

    logic [2:0] code;

    always_comb begin
        code = dir_rev ? ~hall : hall;
        step = step_lookup(code);
    end

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] duty,
    input  logic             ilim_trip,
    output logic             pwm_on
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             trip;
    } tmr_t;

    tmr_t tmr_q, tmr_d;

    always_comb begin
        tmr_d      = tmr_q;
        tmr_d.cnt  = tmr_q.cnt + 1'b1;
        tmr_d.trip = (tmr_q.cnt == CNT_MAX) ? 1'b0 : (tmr_q.trip | ilim_trip);
        pwm_on     = (tmr_q.cnt < duty) && !tmr_q.trip;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    AST_TRIP_CUTS: assert property (@(posedge clk) disable iff (!rst_n)
        (ilim_trip && tmr_q.cnt != CNT_MAX) |=> !pwm_on); // R9

endmodule

// File: rtl/gate_stage.sv
module gate_stage
    import bldc_pkg::*;
#(
    parameter int DEAD_CYC = 80
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PH-1:0] hs_des,
    input  logic [PH-1:0] ls_des,
    output logic [PH-1:0] hs_en,
    output logic [PH-1:0] ls_en
);

    localparam int DT_W = $clog2(DEAD_CYC + 1);

    typedef struct packed {
        logic [PH-1:0]           hs;
        logic [PH-1:0]           ls;
        logic [PH-1:0][DT_W-1:0] dt;
    } gate_t;

    gate_t g_q, g_d;

    always_comb begin
        g_d = g_q;
        for (int p = 0; p < PH; p++) begin
            g_d.hs[p] = hs_des[p] && !g_q.ls[p] && (g_q.dt[p] == '0);
            g_d.ls[p] = ls_des[p] && !g_q.hs[p] && (g_q.dt[p] == '0);
            if ((g_q.hs[p] && !g_d.hs[p]) || (g_q.ls[p] && !g_d.ls[p]))
                g_d.dt[p] = DT_W'(DEAD_CYC);
            else if (g_q.dt[p] != '0)
                g_d.dt[p] = g_q.dt[p] - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign hs_en = g_q.hs;
    assign ls_en = g_q.ls;

    for (genvar p = 0; p < PH; p++) begin : g_chk
        AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
            !(hs_en[p] && ls_en[p])); // R12
        AST_LS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            ls_en[p] |=> !hs_en[p]); // R8
        AST_HS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            hs_en[p] |=> !ls_en[p]); // R8
    end

endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator
    import bldc_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int DEAD_CYC = 80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       hall,
    input  logic             dir_rev,
    input  logic             run,
    input  logic             brake,
    input  logic [CNT_W-1:0] duty,
    input  logic             ilim_trip,
    input  logic             flt_stall,
    input  logic             flt_clkloss,
    input  logic             flt_therm,
    input  logic             flt_uvlo,
    input  logic             init_hold,
    output logic [2:0]       hs_en,
    output logic [2:0]       ls_en
);

    step_t         step;
    logic          pwm_on;
    logic          drive_ok;
    logic          low_flt;
    logic [PH-1:0] hs_des_d;
    logic [PH-1:0] ls_des_d;

    hall_decoder u_dec (
        .hall    (hall),
        .dir_rev (dir_rev),
        .step    (step)
    );

    pwm_timer #(.CNT_W(CNT_W)) u_pwm (
        .clk       (clk),
        .rst_n     (rst_n),
        .duty      (duty),
        .ilim_trip (ilim_trip),
        .pwm_on    (pwm_on)
    );

    always_comb begin
        drive_ok = run && !flt_uvlo && !init_hold;
        low_flt  = flt_stall || flt_clkloss || flt_therm;
        hs_des_d = '0;
        ls_des_d = '0;
        if (drive_ok) begin
            if (brake) begin
                ls_des_d = '1;
            end else if (step.valid) begin
                hs_des_d = step.hi;
                if (!low_flt) begin
                    hs_des_d = step.hi | (step.lo & {PH{!pwm_on}});
                    ls_des_d = step.lo & {PH{pwm_on}};
                end
            end
        end
    end

    gate_stage #(.DEAD_CYC(DEAD_CYC)) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .hs_des (hs_des_d),
        .ls_des (ls_des_d),
        .hs_en  (hs_en),
        .ls_en  (ls_en)
    );

    AST_STOP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (hs_en == '0 && ls_en == '0)); // R4
    AST_SUPPLY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_uvlo || init_hold) |=> (hs_en == '0 && ls_en == '0)); // R11
    AST_BRAKE_NO_HS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && brake) |=> (hs_en == '0)); // R5
    AST_LOWFLT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !brake && (flt_stall || flt_clkloss || flt_therm)) |=> (ls_en == '0)); // R10

endmodule

// File: tb/bldc_commutator_tb.sv
module bldc_commutator_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 10;
    localparam int DEAD       = 80;
    localparam int PER        = 1 << CNT_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       hall = 3'b000;
    logic             dir_rev = 1'b0;
    logic             run = 1'b0;
    logic             brake = 1'b0;
    logic [CNT_W-1:0] duty = '0;
    logic             ilim_trip = 1'b0;
    logic             flt_stall = 1'b0;
    logic             flt_clkloss = 1'b0;
    logic             flt_therm = 1'b0;
    logic             flt_uvlo = 1'b0;
    logic             init_hold = 1'b0;
    logic [2:0]       hs_en;
    logic [2:0]       ls_en;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    int hs_c[3];
    int ls_c[3];
    int ovl = 0;
    int dv = 0;
    int cyc = 0;
    int t_off_ls[3];
    int t_off_hs[3];
    logic [2:0] hs_p = '0;
    logic [2:0] ls_p = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bldc_commutator #(.CNT_W(CNT_W), .DEAD_CYC(DEAD)) dut_i (
        .clk(clk), .rst_n(rst_n), .hall(hall), .dir_rev(dir_rev), .run(run),
        .brake(brake), .duty(duty), .ilim_trip(ilim_trip), .flt_stall(flt_stall),
        .flt_clkloss(flt_clkloss), .flt_therm(flt_therm), .flt_uvlo(flt_uvlo),
        .init_hold(init_hold), .hs_en(hs_en), .ls_en(ls_en)
    );

    // Continuous overlap and dead-interval monitor (R12, R8)
    initial begin
        for (int p = 0; p < 3; p++) begin t_off_ls[p] = -100000; t_off_hs[p] = -100000; end
    end
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            for (int p = 0; p < 3; p++) begin
                if (hs_en[p] && ls_en[p]) ovl <= ovl + 1;
                if (ls_p[p] && !ls_en[p]) t_off_ls[p] <= cyc;
                if (hs_p[p] && !hs_en[p]) t_off_hs[p] <= cyc;
                if (!hs_p[p] && hs_en[p] && (cyc - t_off_ls[p] < DEAD)) dv <= dv + 1;
                if (!ls_p[p] && ls_en[p] && (cyc - t_off_hs[p] < DEAD)) dv <= dv + 1;
            end
        end
        hs_p <= hs_en;
        ls_p <= ls_en;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Independent six-step model: returns high and low phase, -1 if invalid
    function automatic int hi_ph(input logic [2:0] h, input logic rev);
        logic [2:0] c;
        c = rev ? ~h : h;
        case (c)
            3'b101, 3'b001: return 1;
            3'b100, 3'b110: return 2;
            3'b010, 3'b011: return 0;
            default:        return -1;
        endcase
    endfunction

    function automatic int lo_ph(input logic [2:0] h, input logic rev);
        logic [2:0] c;
        c = rev ? ~h : h;
        case (c)
            3'b101, 3'b100: return 0;
            3'b110, 3'b010: return 1;
            3'b011, 3'b001: return 2;
            default:        return -1;
        endcase
    endfunction

    function automatic int exp_ls_on(input int d);
        return (d == 0) ? 0 : d - DEAD - 1;
    endfunction

    function automatic int exp_sync_on(input int d);
        return (d == 0) ? PER : PER - 1 - d - DEAD;
    endfunction

    task automatic measure();
        for (int p = 0; p < 3; p++) begin hs_c[p] = 0; ls_c[p] = 0; end
        repeat (PER) begin
            @(negedge clk);
            for (int p = 0; p < 3; p++) begin
                hs_c[p] += int'(hs_en[p]);
                ls_c[p] += int'(ls_en[p]);
            end
        end
    endtask

    task automatic settle_measure();
        repeat (2 * PER) @(negedge clk);
        measure();
    endtask

    task automatic check_counts(input string req, input int eh0, input int eh1,
                                input int eh2, input int el0, input int el1, input int el2);
        int eh[3];
        int el[3];
        eh[0] = eh0; eh[1] = eh1; eh[2] = eh2;
        el[0] = el0; el[1] = el1; el[2] = el2;
        for (int p = 0; p < 3; p++) begin
            chk(hs_c[p] == eh[p], req, $sformatf("hs_on[%0d]", p), hs_c[p], eh[p]);
            chk(ls_c[p] == el[p], req, $sformatf("ls_on[%0d]", p), ls_c[p], el[p]);
        end
    endtask

    task automatic drive_case(input logic [2:0] h, input logic rev, input int d,
                              input string req);
        int hi;
        int lo;
        int eh[3];
        int el[3];
        @(negedge clk);
        hall = h; dir_rev = rev; duty = CNT_W'(d);
        run = 1'b1; brake = 1'b0;
        settle_measure();
        hi = hi_ph(h, rev);
        lo = lo_ph(h, rev);
        for (int p = 0; p < 3; p++) begin
            eh[p] = (p == hi) ? PER : (p == lo) ? exp_sync_on(d) : 0;
            el[p] = (p == lo) ? exp_ls_on(d) : 0;
        end
        check_counts(req, eh[0], eh[1], eh[2], el[0], el[1], el[2]);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // reset state (R11)
        run = 1'b1; brake = 1'b1; hall = 3'b101;
        repeat (5) @(negedge clk);
        chk(hs_en == 3'b000 && ls_en == 3'b000, "R11", "outputs in reset",
            int'({hs_en, ls_en}), 0);
        rst_n = 1'b1;

        // forward table R1 (and R6/R7 counts)
        drive_case(3'b101, 1'b0, 600, "R1");
        drive_case(3'b100, 1'b0, 500, "R1");
        drive_case(3'b110, 1'b0, 400, "R1");
        drive_case(3'b010, 1'b0, 700, "R1");
        drive_case(3'b011, 1'b0, 300, "R1");
        drive_case(3'b001, 1'b0, 800, "R6");
        // reverse complement R2
        drive_case(3'b010, 1'b1, 600, "R2");
        drive_case(3'b100, 1'b1, 450, "R2");
        // invalid codes R3
        drive_case(3'b000, 1'b0, 500, "R3");
        drive_case(3'b111, 1'b1, 500, "R3");
        // duty zero: full rectification, no chopping R7
        drive_case(3'b110, 1'b0, 0, "R7");

        // random code / direction / duty, R6 R7 plus monitor R8 R12
        for (int i = 0; i < 14; i++) begin
            logic [2:0] h;
            h = 3'($urandom_range(1, 6));
            drive_case(h, 1'($urandom_range(0, 1)), $urandom_range(DEAD + 2, PER - 3 - DEAD), "R6");
        end

        // stop R4
        @(negedge clk); run = 1'b0; brake = 1'b1; hall = 3'b101; duty = 10'd500;
        settle_measure();
        check_counts("R4", 0, 0, 0, 0, 0, 0);

        // brake with current limit held and a low-side fault R5
        @(negedge clk); run = 1'b1; brake = 1'b1; duty = '0; ilim_trip = 1'b1; flt_stall = 1'b1;
        settle_measure();
        check_counts("R5", 0, 0, 0, PER, PER, PER);

        // undervoltage and init hold beat brake R11
        @(negedge clk); flt_stall = 1'b0; flt_uvlo = 1'b1;
        settle_measure();
        check_counts("R11", 0, 0, 0, 0, 0, 0);
        @(negedge clk); flt_uvlo = 1'b0; init_hold = 1'b1;
        settle_measure();
        check_counts("R11", 0, 0, 0, 0, 0, 0);
        @(negedge clk); init_hold = 1'b0; brake = 1'b0; ilim_trip = 1'b0;

        // low-side faults while driving R10: code 100 fwd, hi W, lo U
        @(negedge clk); hall = 3'b100; dir_rev = 1'b0; duty = 10'd500; flt_therm = 1'b1;
        settle_measure();
        check_counts("R10", 0, 0, PER, 0, 0, 0);
        @(negedge clk); flt_therm = 1'b0; flt_clkloss = 1'b1; hall = 3'b011;
        settle_measure();
        check_counts("R10", PER, 0, 0, 0, 0, 0);
        @(negedge clk); flt_clkloss = 1'b0;

        // current limit held: low side never on R9 (code 101 fwd: hi V, lo U)
        @(negedge clk); hall = 3'b101; duty = 10'd600; ilim_trip = 1'b1;
        settle_measure();
        chk(ls_c[0] == 0, "R9", "ls_on[0] with trip held", ls_c[0], 0);
        @(negedge clk); ilim_trip = 1'b0;
        repeat (2 * PER) @(negedge clk);

        // single trip pulse inside the on-time R9
        while (ls_en[0]) @(negedge clk);
        while (!ls_en[0]) @(negedge clk);
        repeat (10) @(negedge clk);
        ilim_trip = 1'b1;
        @(negedge clk); ilim_trip = 1'b0;
        @(negedge clk);
        chk(ls_en[0] == 1'b0, "R9", "ls_en[0] two clocks after trip", int'(ls_en[0]), 0);
        begin
            int on_rest;
            on_rest = 0;
            repeat (400) begin
                @(negedge clk);
                on_rest += int'(ls_en[0]);
            end
            chk(on_rest == 0, "R9", "ls on-count after trip in same period", on_rest, 0);
        end
        repeat (PER) @(negedge clk);
        measure();
        chk(ls_c[0] == exp_ls_on(600), "R9", "ls_on[0] in following period", ls_c[0], exp_ls_on(600));

        // monitor results
        chk(ovl == 0, "R12", "same-phase overlap cycles", ovl, 0);
        chk(dv == 0, "R8", "dead interval violations", dv, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule